// File: doc/BRIEF.md
# Address-Space-Tagged Associative Translation Buffer

This block caches page translations in a fully associative table of parameterised depth. Each slot stores a virtual page number, a physical frame number, an address space number and a global flag. It also stores a per-privilege-mode read enable and write enable, and two fault-on-access flags, one for reads and one for writes. A single combinational lookup port compares a page number and the current address space number against every slot in the same cycle. It returns a hit flag, the index of the matching slot and that slot's fields.

Software maintenance happens through a set of synchronous controls. These are insert, flush everything, flush every non-global slot, and flush one page for one address space. A rotating next-location pointer picks the slot that each insert overwrites. A read-index port shows the slot under that pointer and can step the pointer without writing anything. Page table walking, address arithmetic and fault reporting are left to the surrounding logic.

Top module: `tlb_assoc`

## Requirements
- R1: A slot matches a lookup only when it is valid, its stored page number equals `lk_vpn`, and either its global flag is 1 or its stored address space number equals `lk_asn`.
- R2: When several slots match, `lk_idx` names the lowest matching index and the field outputs come from that slot; the lookup result is combinational and valid in the same cycle.
- R3: An insert writes the slot under the next-location pointer at the clock edge, marks it valid, and takes its page number from `ins_vaddr[31:13]`. Any valid entry already held there is evicted without any other check.
- R4: The next-location pointer steps by one after a cycle with an insert or with `nx_adv` high (one step even if both are high), wraps from DEPTH-1 to 0, and holds otherwise.
- R5: A page flush (`inv_addr`) clears every valid slot whose page number equals `inv_vaddr[31:13]` and that is global or carries `inv_asn`; other slots are kept.
- R6: A non-global flush (`inv_nonglob`) clears every slot whose global flag is 0 and keeps global slots.
- R7: A full flush (`inv_all`) returns the table to its reset state: all slots invalid and the pointer at 0. It overrides any insert, selective flush or pointer step in the same cycle.
- R8: `nx_ptr`, `nx_valid`, `nx_tag` and `nx_pfn` show the pointer and the slot it names.
- R9: On a hit the outputs carry the slot's frame number, global flag, read enables, write enables and fault flags. On a miss all of these outputs are 0.
- R10: After reset every slot is invalid, every lookup misses and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | 19 | Lookup page number |
| lk_asn | input | 8 | Lookup address space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | $clog2(DEPTH) | Index of the winning slot |
| lk_pfn | output | 20 | Frame number of the winning slot |
| lk_glob | output | 1 | Global flag of the winning slot |
| lk_rd_en | output | 4 | Read enable per privilege mode |
| lk_wr_en | output | 4 | Write enable per privilege mode |
| lk_flt_rd | output | 1 | Fault-on-read flag |
| lk_flt_wr | output | 1 | Fault-on-write flag |
| ins_valid | input | 1 | Insert strobe |
| ins_vaddr | input | 32 | Virtual address of the new entry |
| ins_pfn | input | 20 | Frame number of the new entry |
| ins_asn | input | 8 | Address space number of the new entry |
| ins_glob | input | 1 | Global flag of the new entry |
| ins_rd_en | input | 4 | Read enables of the new entry |
| ins_wr_en | input | 4 | Write enables of the new entry |
| ins_flt_rd | input | 1 | Fault-on-read of the new entry |
| ins_flt_wr | input | 1 | Fault-on-write of the new entry |
| inv_all | input | 1 | Full flush |
| inv_nonglob | input | 1 | Flush of all non-global slots |
| inv_addr | input | 1 | Page flush strobe |
| inv_vaddr | input | 32 | Address for the page flush |
| inv_asn | input | 8 | Address space number for the page flush |
| nx_adv | input | 1 | Step the next-location pointer |
| nx_ptr | output | $clog2(DEPTH) | Next-location pointer |
| nx_valid | output | 1 | Valid flag of the slot under the pointer |
| nx_tag | output | 19 | Page number of the slot under the pointer |
| nx_pfn | output | 20 | Frame number of the slot under the pointer |

## Verification
The bench loads one page number into three slots: one private, one private with a different space number, and one global. Lookups that match two slots then show whether the lowest index wins; a design that gave priority to the highest index would return the global slot instead. A page flush aimed at one space number must also remove the global copy but spare the other private one, and a non-global flush must leave a global slot in place. The bench also drives the pointer through its wrap and evicts a global slot through an insert. It issues a full flush together with an insert to show the flush wins, which a design that let the insert through would reveal as a stray hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W    = 32;
    localparam int PG_BITS = 13;
    localparam int VPN_W   = VA_W - PG_BITS;
    localparam int PFN_W   = 20;
    localparam int ASN_W   = 8;
    localparam int NMODE   = 4;

    typedef struct packed {
        logic [VPN_W-1:0] tag;
        logic [PFN_W-1:0] pfn;
        logic [ASN_W-1:0] asn;
        logic             glob;
        logic [NMODE-1:0] rd_en;
        logic [NMODE-1:0] wr_en;
        logic             flt_rd;
        logic             flt_wr;
    } tlb_ent_t;

    function automatic logic [VPN_W-1:0] va_vpn(input logic [VA_W-1:0] va);
        return va[VA_W-1:PG_BITS];
    endfunction

    function automatic logic ent_hits(input tlb_ent_t e, input logic v,
                                      input logic [VPN_W-1:0] vpn,
                                      input logic [ASN_W-1:0] asn);
        return v && (e.tag == vpn) && (e.glob || (e.asn == asn));
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  tlb_ent_t         ents [DEPTH],
    input  logic [DEPTH-1:0] vld,
    input  logic [VPN_W-1:0] vpn,
    input  logic [ASN_W-1:0] asn,
    output logic [DEPTH-1:0] hits
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hits[g] = ent_hits(ents[g], vld[g], vpn, asn);
    end
endmodule

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
    parameter int N  = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_nlu_ptr.sv
module tlb_nlu_ptr #(
    parameter int DEPTH = 64,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    output logic [IW-1:0] ptr
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
    import tlb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [IW-1:0]    lk_idx,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_glob,
    output logic [NMODE-1:0] lk_rd_en,
    output logic [NMODE-1:0] lk_wr_en,
    output logic             lk_flt_rd,
    output logic             lk_flt_wr,
    input  logic             ins_valid,
    input  logic [VA_W-1:0]  ins_vaddr,
    input  logic [PFN_W-1:0] ins_pfn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_glob,
    input  logic [NMODE-1:0] ins_rd_en,
    input  logic [NMODE-1:0] ins_wr_en,
    input  logic             ins_flt_rd,
    input  logic             ins_flt_wr,
    input  logic             inv_all,
    input  logic             inv_nonglob,
    input  logic             inv_addr,
    input  logic [VA_W-1:0]  inv_vaddr,
    input  logic [ASN_W-1:0] inv_asn,
    input  logic             nx_adv,
    output logic [IW-1:0]    nx_ptr,
    output logic             nx_valid,
    output logic [VPN_W-1:0] nx_tag,
    output logic [PFN_W-1:0] nx_pfn
);
    tlb_ent_t         ent_q [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] glob_q;
    logic [DEPTH-1:0] lk_hits;
    logic [DEPTH-1:0] inv_hits;
    logic [DEPTH-1:0] clr_mask;
    logic             do_ins;
    tlb_ent_t         new_ent;
    tlb_ent_t         sel_ent;

    for (genvar g = 0; g < DEPTH; g++) begin : g_glob
        assign glob_q[g] = ent_q[g].glob;
    end

    tlb_match #(.DEPTH(DEPTH)) u_lk_match (
        .ents (ent_q),
        .vld  (valid_q),
        .vpn  (lk_vpn),
        .asn  (lk_asn),
        .hits (lk_hits)
    );

    tlb_match #(.DEPTH(DEPTH)) u_inv_match (
        .ents (ent_q),
        .vld  (valid_q),
        .vpn  (va_vpn(inv_vaddr)),
        .asn  (inv_asn),
        .hits (inv_hits)
    );

    tlb_first_set #(.N(DEPTH)) u_pick (
        .vec   (lk_hits),
        .found (lk_hit),
        .idx   (lk_idx)
    );

    tlb_nlu_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .clear (inv_all),
        .step  (ins_valid || nx_adv),
        .ptr   (nx_ptr)
    );

    assign do_ins = ins_valid && !inv_all;

    always_comb begin
        clr_mask = '0;
        if (inv_nonglob) clr_mask = clr_mask | ~glob_q;
        if (inv_addr)    clr_mask = clr_mask | inv_hits;
    end

    always_comb begin
        new_ent.tag    = va_vpn(ins_vaddr);
        new_ent.pfn    = ins_pfn;
        new_ent.asn    = ins_asn;
        new_ent.glob   = ins_glob;
        new_ent.rd_en  = ins_rd_en;
        new_ent.wr_en  = ins_wr_en;
        new_ent.flt_rd = ins_flt_rd;
        new_ent.flt_wr = ins_flt_wr;
    end

    always_ff @(posedge clk) begin
        if (rst || inv_all) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_q & ~clr_mask;
            if (ins_valid) valid_q[nx_ptr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (do_ins) begin
            ent_q[nx_ptr] <= new_ent;
        end
    end

    always_comb begin
        sel_ent = lk_hit ? ent_q[lk_idx] : '0;
        lk_pfn    = sel_ent.pfn;
        lk_glob   = sel_ent.glob;
        lk_rd_en  = sel_ent.rd_en;
        lk_wr_en  = sel_ent.wr_en;
        lk_flt_rd = sel_ent.flt_rd;
        lk_flt_wr = sel_ent.flt_wr;
    end

    assign nx_valid = valid_q[nx_ptr];
    assign nx_tag   = ent_q[nx_ptr].tag;
    assign nx_pfn   = ent_q[nx_ptr].pfn;
endmodule

// File: rtl/tlb_assoc_checker.sv
module tlb_assoc_checker
    import tlb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_hit,
    input logic [IW-1:0]    lk_idx,
    input logic [PFN_W-1:0] lk_pfn,
    input logic [NMODE-1:0] lk_rd_en,
    input logic             ins_valid,
    input logic             inv_all,
    input logic             inv_nonglob,
    input logic             nx_adv,
    input logic [IW-1:0]    nx_ptr,
    input logic [DEPTH-1:0] valid_q,
    input logic [DEPTH-1:0] glob_q
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    // R10: one cycle after reset the table is empty and the pointer at zero
    a_r10_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (valid_q == '0 && nx_ptr == '0));

    // R7: full flush empties the table and rewinds the pointer
    a_r7_flush_all: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (valid_q == '0 && nx_ptr == '0));

    // R4: pointer steps and wraps
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (!inv_all && (ins_valid || nx_adv)) |=>
        nx_ptr == (($past(nx_ptr) == LAST) ? '0 : $past(nx_ptr) + 1'b1));

    // R4: pointer holds without a step request
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (!inv_all && !ins_valid && !nx_adv) |=> $stable(nx_ptr));

    // R3: inserted slot is valid afterwards
    a_r3_insert_valid: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !inv_all) |=> valid_q[$past(nx_ptr)]);

    // R6: after a non-global flush only global slots remain
    a_r6_keep_global: assert property (@(posedge clk) disable iff (rst)
        (inv_nonglob && !inv_all && !ins_valid) |=> ((valid_q & ~glob_q) == '0));

    // R1: a hit always names a valid slot
    a_r1_hit_valid: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> valid_q[lk_idx]);

    // R9: miss drives zero fields
    a_r9_miss_zero: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pfn == '0 && lk_rd_en == '0));
endmodule

bind tlb_assoc tlb_assoc_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_hit      (lk_hit),
    .lk_idx      (lk_idx),
    .lk_pfn      (lk_pfn),
    .lk_rd_en    (lk_rd_en),
    .ins_valid   (ins_valid),
    .inv_all     (inv_all),
    .inv_nonglob (inv_nonglob),
    .nx_adv      (nx_adv),
    .nx_ptr      (nx_ptr),
    .valid_q     (valid_q),
    .glob_q      (glob_q)
);

// File: tb/tlb_assoc_bench.sv
`timescale 1ns/1ps
module tlb_assoc_bench;
    import tlb_pkg::*;

    localparam int DEPTH = 4;
    localparam int IW = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic [ASN_W-1:0] lk_asn = '0;
    logic             lk_hit;
    logic [IW-1:0]    lk_idx;
    logic [PFN_W-1:0] lk_pfn;
    logic             lk_glob;
    logic [NMODE-1:0] lk_rd_en;
    logic [NMODE-1:0] lk_wr_en;
    logic             lk_flt_rd;
    logic             lk_flt_wr;
    logic             ins_valid = 1'b0;
    logic [VA_W-1:0]  ins_vaddr = '0;
    logic [PFN_W-1:0] ins_pfn = '0;
    logic [ASN_W-1:0] ins_asn = '0;
    logic             ins_glob = 1'b0;
    logic [NMODE-1:0] ins_rd_en = '0;
    logic [NMODE-1:0] ins_wr_en = '0;
    logic             ins_flt_rd = 1'b0;
    logic             ins_flt_wr = 1'b0;
    logic             inv_all = 1'b0;
    logic             inv_nonglob = 1'b0;
    logic             inv_addr = 1'b0;
    logic [VA_W-1:0]  inv_vaddr = '0;
    logic [ASN_W-1:0] inv_asn = '0;
    logic             nx_adv = 1'b0;
    logic [IW-1:0]    nx_ptr;
    logic             nx_valid;
    logic [VPN_W-1:0] nx_tag;
    logic [PFN_W-1:0] nx_pfn;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tlb_assoc #(.DEPTH(DEPTH)) u_tlb_assoc (.*);

    // lookup vectors after four inserts (R1, R2): vpn, asn, hit, idx, pfn
    localparam int NV = 6;
    localparam int unsigned V_VPN [NV] = '{32'h100, 32'h100, 32'h100, 32'h200, 32'h200, 32'h300};
    localparam int unsigned V_ASN [NV] = '{5, 9, 1, 0, 7, 5};
    localparam int unsigned V_HIT [NV] = '{1, 1, 1, 1, 1, 0};
    localparam int unsigned V_IDX [NV] = '{0, 2, 3, 1, 1, 0};
    localparam int unsigned V_PFN [NV] = '{32'hA0, 32'hC0, 32'hD0, 32'hB0, 32'hB0, 0};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic look(input int vpn, input int asn, input bit eh, input int ei,
                        input int ep, input string req);
        @(negedge clk);
        lk_vpn = VPN_W'(vpn);
        lk_asn = ASN_W'(asn);
        #1;
        chk(lk_hit == eh, {req, " hit"}, lk_hit, eh);
        if (eh) chk(lk_idx == IW'(ei), {req, " idx"}, lk_idx, ei);
        chk(lk_pfn == PFN_W'(ep), {req, " pfn"}, lk_pfn, ep);
    endtask

    task automatic put(input int vpn, input int pfn, input int asn, input bit glob);
        @(negedge clk);
        ins_valid = 1'b1;
        ins_vaddr = {VPN_W'(vpn), 13'h0a5};
        ins_pfn   = PFN_W'(pfn);
        ins_asn   = ASN_W'(asn);
        ins_glob  = glob;
        ins_rd_en = 4'b0011;
        ins_wr_en = 4'b0001;
        ins_flt_rd = 1'b1;
        ins_flt_wr = 1'b0;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        #1;
        chk(nx_ptr == 0, "R10 ptr", nx_ptr, 0);
        look(32'h100, 5, 0, 0, 0, "R10 empty");

        // R3 / R4: four inserts fill slots 0..3, pointer wraps to 0
        put(32'h100, 32'hA0, 5, 0);
        put(32'h200, 32'hB0, 7, 1);
        put(32'h100, 32'hC0, 9, 0);
        put(32'h100, 32'hD0, 3, 1);
        #1;
        chk(nx_ptr == 0, "R4 wrap", nx_ptr, 0);
        chk(nx_tag == VPN_W'(32'h100), "R3 tag from vaddr", nx_tag, 32'h100);

        // vector table: R1 matching and R2 lowest index
        for (int i = 0; i < NV; i++) begin
            look(V_VPN[i], V_ASN[i], V_HIT[i] != 0, V_IDX[i], V_PFN[i], "R1/R2 vector");
        end

        // R9: fields of the hit slot
        look(32'h100, 5, 1, 0, 32'hA0, "R9");
        chk(lk_rd_en == 4'b0011 && lk_wr_en == 4'b0001, "R9 enables",
            {lk_rd_en, lk_wr_en}, 8'h31);
        chk(lk_flt_rd == 1'b1 && lk_flt_wr == 1'b0 && lk_glob == 1'b0, "R9 flags",
            {lk_flt_rd, lk_flt_wr, lk_glob}, 3'b100);

        // R5: page flush for space 9 removes slot 2 and global slot 3, keeps slot 0
        @(negedge clk);
        inv_addr = 1'b1;
        inv_vaddr = {VPN_W'(32'h100), 13'h1fff};
        inv_asn = 8'd9;
        @(negedge clk);
        inv_addr = 1'b0;
        look(32'h100, 9, 0, 0, 0, "R5 private cleared");
        look(32'h100, 1, 0, 0, 0, "R5 global cleared");
        look(32'h100, 5, 1, 0, 32'hA0, "R5 other space kept");

        // R6: non-global flush keeps global slot 1
        @(negedge clk);
        inv_nonglob = 1'b1;
        @(negedge clk);
        inv_nonglob = 1'b0;
        look(32'h100, 5, 0, 0, 0, "R6 private cleared");
        look(32'h200, 0, 1, 1, 32'hB0, "R6 global kept");

        // R3: eviction of global slot 1 by the rotating pointer
        put(32'h400, 32'hE0, 2, 0);
        put(32'h500, 32'hF0, 2, 0);
        look(32'h200, 0, 0, 0, 0, "R3 evicted");
        look(32'h500, 2, 1, 1, 32'hF0, "R3 new entry");

        // R8: read-index port and pointer step without insert
        #1;
        chk(nx_ptr == 2, "R8 ptr", nx_ptr, 2);
        chk(nx_valid == 1'b0, "R8 slot empty", nx_valid, 0);
        @(negedge clk);
        nx_adv = 1'b1;
        @(negedge clk);
        nx_adv = 1'b0;
        #1;
        chk(nx_ptr == 3, "R8 advance", nx_ptr, 3);
        @(negedge clk);
        nx_adv = 1'b1;
        @(negedge clk);
        nx_adv = 1'b0;
        #1;
        chk(nx_ptr == 0 && nx_valid && nx_pfn == PFN_W'(32'hE0), "R8 slot 0",
            nx_pfn, 32'hE0);

        // R7: full flush wins over a simultaneous insert
        @(negedge clk);
        inv_all = 1'b1;
        ins_valid = 1'b1;
        ins_vaddr = {VPN_W'(32'h600), 13'h0};
        ins_asn = 8'd1;
        @(negedge clk);
        inv_all = 1'b0;
        ins_valid = 1'b0;
        #1;
        chk(nx_ptr == 0 && !nx_valid, "R7 reset state", {nx_ptr, nx_valid}, 0);
        look(32'h600, 1, 0, 0, 0, "R7 insert dropped");
        look(32'h400, 2, 0, 0, 0, "R7 old entry gone");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule